// File: doc/BRIEF.md
# Single-Channel Block Mover with Bus Hold and Idle-Cycle Stealing

This block copies a run of bytes between memory and one peripheral without the processor taking part. Software sets it up through a small register port: a start address, a byte count and a mode word. The mode word picks one of two ways to get memory access. In the first way, the engine asks the processor to release the bus and keeps the bus until the whole block has moved. In the second way, the engine moves single bytes, and only in cycles that the processor reports as unused, so the processor never stops.

A transfer begins when the peripheral raises its request. In hold mode the engine raises a hold request. It then waits as many cycles as the processor needs to reach a grant. After that it moves one byte per cycle for as long as the grant and the peripheral request both stay high. In steal mode it moves one byte in every cycle where the processor flags the bus idle and the peripheral is requesting. After the final byte the engine lets go of the bus, sets a done flag and pulses an interrupt.

The memory side is a simple synchronous master port. Read data is taken in the same cycle as the address. Write data is taken at the clock edge that ends the access cycle. The direction bit in the mode word decides whether bytes travel from memory to the peripheral or from the peripheral to memory. Register writes are accepted only while the engine is idle.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is held, holdReq, memEn, memWe, perAck, done and irq are all 0.
- R2: Writing a count of zero (regSel = 1) is ignored. The stored count is unchanged, no hold request and no memory access follow even with perReq high, and done keeps its value.
- R3: In hold mode (mode bit 0 = 1), holdReq rises in the cycle after perReq is seen. memEn stays 0 in every cycle before holdAck has been sampled high.
- R4: In hold mode, once the grant is seen, one byte moves in every cycle while holdAck and perReq are both high. A full block therefore takes count consecutive cycles.
- R5: In steal mode (mode bit 0 = 0), holdReq never rises and a byte moves only in a cycle where busIdle is 1.
- R6: memEn is never high unless holdAck or busIdle is high in the same cycle, so the engine and the processor never use memory together.
- R7: Mode bit 1 = 0 moves data from the peripheral to memory: memWe = 1 and memWdata = perRdata. Mode bit 1 = 1 moves data from memory to the peripheral: memWe = 0 and perWdata = memRdata. perAck is high in every transfer cycle.
- R8: The k-th transfer of a block (k from 0) uses address start + k. Exactly count transfers take place.
- R9: In the cycle after the last transfer, holdReq is 0, done is 1 and irq is 1. irq is 0 again one cycle later. A nonzero count write clears done.
- R10: An armed engine makes no memory access while perReq is 0, even when busIdle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 count (nonzero arms), 2 mode |
| regWdata | input | ADDR_W | Register write data |
| perReq | input | 1 | Peripheral transfer request |
| perRdata | input | DATA_W | Byte from the peripheral |
| perWdata | output | DATA_W | Byte to the peripheral |
| perAck | output | 1 | A byte moves this cycle |
| holdReq | output | 1 | Bus hold request to the processor |
| holdAck | input | 1 | Bus grant from the processor |
| busIdle | input | 1 | Processor leaves memory unused this cycle |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data |
| done | output | 1 | Block finished |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest case to reach is the grant window in hold mode. The engine has already asked for the bus but has not yet been granted it, and it must stay off the memory port however long the processor takes. The stimulus table gives each hold-mode case its own grant delay, from zero to several cycles, and the bench answers holdReq only after that delay. In steal mode, an irregular idle pattern breaks transfers into gaps. Each memory access is checked against the idle flag and the expected address.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_HOLDWAIT,
    ST_BURST
  } dmaState_t;

  typedef struct packed {
    logic cfgOpen;
    logic step;
  } dmaStrobe_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;

  localparam int MODE_BURST_BIT = 0;
  localparam int MODE_DIR_BIT   = 1;
  localparam int MODE_W         = 2;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] perRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] perWdata,
  output logic              modeBurst,
  output logic              modeDir,
  output logic              lastBeat,
  output logic              armReq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remCount;
  logic [MODE_W-1:0] modeReg;
  logic              cfgWrite;
  logic              countNonZero;

  assign cfgWrite     = strobe.cfgOpen && regWe;
  assign countNonZero = |regWdata[CNT_W-1:0];
  assign armReq       = cfgWrite && (regSel == SEL_COUNT) && countNonZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remCount <= '0;
      modeReg  <= '0;
    end else if (cfgWrite) begin
      case (regSel)
        SEL_ADDR:  curAddr <= regWdata;
        SEL_COUNT: if (countNonZero) remCount <= regWdata[CNT_W-1:0];
        SEL_MODE:  modeReg <= regWdata[MODE_W-1:0];
        default:   ;
      endcase
    end else if (strobe.step) begin
      curAddr  <= curAddr + ADDR_W'(1);
      remCount <= remCount - CNT_ONE;
    end
  end

  assign memAddr   = curAddr;
  assign memWdata  = perRdata;
  assign perWdata  = memRdata;
  assign modeBurst = modeReg[MODE_BURST_BIT];
  assign modeDir   = modeReg[MODE_DIR_BIT];
  assign lastBeat  = (remCount == CNT_ONE);

  // R2: a zero count written while idle leaves the stored count alone
  assert_zero_count_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && regSel == SEL_COUNT && !countNonZero) |=> $stable(remCount));

  // R8: no transfer is ever issued with nothing left to move
  assert_step_has_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (remCount != '0));
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armReq,
  input  logic       modeBurst,
  input  logic       lastBeat,
  input  logic       perReq,
  input  logic       holdAck,
  input  logic       busIdle,
  output dmaStrobe_t strobe,
  output logic       holdReq,
  output logic       done,
  output logic       irq
);
  dmaState_t state, stateNext;
  logic      step;
  logic      finish;

  always_comb begin
    stateNext = state;
    step      = 1'b0;
    holdReq   = 1'b0;
    case (state)
      ST_IDLE: if (armReq) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (modeBurst) begin
          if (perReq) stateNext = ST_HOLDWAIT;
        end else begin
          step = perReq && busIdle;
          if (step && lastBeat) stateNext = ST_IDLE;
        end
      end
      ST_HOLDWAIT: begin
        holdReq = 1'b1;
        if (holdAck) stateNext = ST_BURST;
      end
      ST_BURST: begin
        holdReq = 1'b1;
        step    = holdAck && perReq;
        if (step && lastBeat) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign finish         = step && lastBeat;
  assign strobe.step    = step;
  assign strobe.cfgOpen = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= stateNext;
      irq   <= finish;
      if (finish)      done <= 1'b1;
      else if (armReq) done <= 1'b0;
    end
  end

  // R3: a hold-mode access only follows a cycle in which the bus was requested
  assert_burst_after_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (step && modeBurst) |-> $past(holdReq));

  // R5: steal mode never asks for the bus
  assert_steal_no_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !modeBurst |-> !holdReq);

  // R6: an access needs either the grant or an idle processor cycle
  assert_grant_or_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    step |-> (holdAck || busIdle));

  // R10: no access without a peripheral request
  assert_request_gates_R10: assert property (@(posedge clk) disable iff (!rstN)
    step |-> perReq);

  // R9: interrupt lasts one cycle and comes with the bus released
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  assert_irq_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (done && !holdReq));
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              perReq,
  input  logic [DATA_W-1:0] perRdata,
  output logic [DATA_W-1:0] perWdata,
  output logic              perAck,
  output logic              holdReq,
  input  logic              holdAck,
  input  logic              busIdle,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic              irq
);
  dmaStrobe_t strobe;
  logic       modeBurst;
  logic       modeDir;
  logic       lastBeat;
  logic       armReq;

  dma_datapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWdata (regWdata),
    .memRdata (memRdata),
    .perRdata (perRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .perWdata (perWdata),
    .modeBurst(modeBurst),
    .modeDir  (modeDir),
    .lastBeat (lastBeat),
    .armReq   (armReq)
  );

  dma_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .armReq   (armReq),
    .modeBurst(modeBurst),
    .lastBeat (lastBeat),
    .perReq   (perReq),
    .holdAck  (holdAck),
    .busIdle  (busIdle),
    .strobe   (strobe),
    .holdReq  (holdReq),
    .done     (done),
    .irq      (irq)
  );

  assign memEn  = strobe.step;
  assign memWe  = strobe.step && !modeDir;
  assign perAck = strobe.step;

  // R7: a read toward the peripheral never writes memory
  assert_dir_read_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && modeDir) |-> !memWe);
endmodule

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int NVEC   = 6;

  // {burst, dir, grantDelay[5:0], idleMask[7:0], start[7:0], count[7:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 6'd3, 8'h00,        8'h10, 8'd4},
    {1'b1, 1'b1, 6'd0, 8'h00,        8'h40, 8'd5},
    {1'b0, 1'b0, 6'd0, 8'b10110010,  8'h20, 8'd6},
    {1'b0, 1'b1, 6'd0, 8'b01001001,  8'h80, 8'd3},
    {1'b1, 1'b0, 6'd7, 8'h00,        8'h30, 8'd1},
    {1'b0, 1'b0, 6'd0, 8'hFF,        8'h60, 8'd2}
  };

  logic              clk, rstN, regWe, perReq, holdAck, busIdle;
  logic [1:0]        regSel;
  logic [ADDR_W-1:0] regWdata, memAddr;
  logic [DATA_W-1:0] perRdata, perWdata, memWdata, memRdata;
  logic              perAck, holdReq, memEn, memWe, done, irq;
  logic [7:0]        benchMem [256];
  int                nChecks = 0;
  int                nFail   = 0;

  dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_dma_xfer_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .perReq(perReq), .perRdata(perRdata), .perWdata(perWdata), .perAck(perAck),
    .holdReq(holdReq), .holdAck(holdAck), .busIdle(busIdle), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .done(done), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign memRdata = benchMem[memAddr[7:0]];
  always @(posedge clk) if (memEn && memWe) benchMem[memAddr[7:0]] <= memWdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [ADDR_W-1:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic runCase(input logic [31:0] v);
    logic burst, dir;
    logic [5:0] delay;
    logic [7:0] mask, start, cnt;
    int xfers, holdCycles, firstCyc, lastCyc;
    bit finished;
    {burst, dir, delay, mask, start, cnt} = v;
    regWrite(2'd0, ADDR_W'(start));
    regWrite(2'd2, ADDR_W'({dir, burst}));
    regWrite(2'd1, ADDR_W'(cnt));
    #1;
    check(done == 1'b0, "R9 done cleared by arm", 32'(done), 0);
    perReq = 1'b1;
    xfers = 0; holdCycles = 0; firstCyc = -1; lastCyc = -1; finished = 0;
    for (int cyc = 0; cyc < 300 && !finished; cyc++) begin
      @(negedge clk);
      if (burst && cyc == 0) check(holdReq == 1'b1, "R3 hold raised", 32'(holdReq), 1);
      if (holdReq) begin
        holdAck = (holdCycles >= int'(delay));
        holdCycles++;
      end else begin
        holdAck = 1'b0;
        holdCycles = 0;
      end
      busIdle  = burst ? 1'b0 : mask[cyc % 8];
      perRdata = 8'hC0 + 8'(xfers);
      #1;
      if (!burst) check(!holdReq, "R5 no hold in steal", 32'(holdReq), 0);
      if (burst) check(!(memEn && !holdAck), "R3 access before grant", 32'(memEn), 0);
      if (memEn) begin
        check(holdAck || busIdle, "R6 shared bus", 32'({holdAck, busIdle}), 1);
        if (!burst) check(busIdle, "R5 idle cycle only", 32'(busIdle), 1);
        check(memAddr == ADDR_W'(start) + ADDR_W'(xfers), "R8 address", 32'(memAddr),
              32'(ADDR_W'(start) + ADDR_W'(xfers)));
        check(perAck, "R7 perAck", 32'(perAck), 1);
        if (dir) begin
          check(!memWe, "R7 read direction", 32'(memWe), 0);
          check(perWdata == ((start + 8'(xfers)) ^ 8'h5A), "R7 byte to peripheral",
                32'(perWdata), 32'((start + 8'(xfers)) ^ 8'h5A));
        end else begin
          check(memWe, "R7 write direction", 32'(memWe), 1);
        end
        if (firstCyc < 0) firstCyc = cyc;
        lastCyc = cyc;
        xfers++;
        if (xfers == int'(cnt)) finished = 1;
      end
    end
    check(xfers == int'(cnt), "R8 transfer count", 32'(xfers), 32'(cnt));
    if (burst) check(lastCyc - firstCyc == int'(cnt) - 1, "R4 back-to-back",
                     32'(lastCyc - firstCyc), 32'(int'(cnt) - 1));
    @(negedge clk);
    holdAck = 1'b0; busIdle = 1'b0; perReq = 1'b0;
    #1;
    check(irq == 1'b1, "R9 irq", 32'(irq), 1);
    check(done == 1'b1, "R9 done", 32'(done), 1);
    check(holdReq == 1'b0, "R9 hold released", 32'(holdReq), 0);
    @(negedge clk);
    #1;
    check(irq == 1'b0, "R9 irq one cycle", 32'(irq), 0);
    if (!dir)
      for (int k = 0; k < int'(cnt); k++)
        check(benchMem[start + 8'(k)] == 8'hC0 + 8'(k), "R7 byte in memory",
              32'(benchMem[start + 8'(k)]), 32'(8'hC0 + 8'(k)));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) benchMem[i] = 8'(i) ^ 8'h5A;
    rstN = 1'b0; regWe = 1'b0; regSel = '0; regWdata = '0;
    perReq = 1'b0; perRdata = '0; holdAck = 1'b0; busIdle = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check({holdReq, memEn, memWe, perAck, done, irq} == '0, "R1 reset outputs",
          32'({holdReq, memEn, memWe, perAck, done, irq}), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runCase(VECS[i]);

    // R2: zero count after completion, with hold mode selected
    regWrite(2'd2, ADDR_W'(2'b01));
    regWrite(2'd1, '0);
    perReq = 1'b1; busIdle = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      #1;
      check(!holdReq && !memEn, "R2 zero count ignored", 32'({holdReq, memEn}), 0);
      check(done == 1'b1, "R2 done kept", 32'(done), 1);
    end
    perReq = 1'b0; busIdle = 1'b0;

    // R10: armed steal transfer waits for the peripheral
    regWrite(2'd0, ADDR_W'(8'h70));
    regWrite(2'd2, ADDR_W'(2'b00));
    regWrite(2'd1, ADDR_W'(1));
    busIdle = 1'b1; perRdata = 8'h3C;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #1;
      check(!memEn, "R10 no request no access", 32'(memEn), 0);
    end
    @(negedge clk);
    perReq = 1'b1;
    #1;
    check(memEn && memAddr == ADDR_W'(8'h70), "R10 access on request",
          32'({memEn, memAddr}), 32'({1'b1, ADDR_W'(8'h70)}));
    @(negedge clk);
    perReq = 1'b0; busIdle = 1'b0;
    #1;
    check(irq && done, "R9 irq after single steal", 32'({irq, done}), 3);
    check(benchMem[8'h70] == 8'h3C, "R7 steal byte stored", 32'(benchMem[8'h70]), 32'h3C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule